// File: doc/BRIEF.md
# Time-Slotted Shared Memory Scheduler

This block shares a single fixed-latency memory port between a slow 8-bit CPU and a video fetch engine. Time is cut into repeating frames of 100 clock cycles (1 us at 100 MHz). Each frame has the same ordered sequence of slots: a CPU read, an optional CPU write back to the same word, one refresh command, and three 16-bit video word fetches, one from each of three 16 KB regions. Every slot begins at a fixed cycle of the frame, so the CPU gets the same access time in every frame whether or not a refresh or a video fetch is due.

The memory is 16 bits wide while the CPU works on bytes. A CPU write is therefore done as read-merge-write: the read slot always runs and fetches the whole word, and the write slot stores that word with the addressed byte replaced. The CPU request and the video offset are sampled once per frame, in the cycle where `frm_sync` is high. The byte the CPU read stays on `cpu_rdata` for a whole frame. The three video words appear together, marked by a one-cycle `vid_valid` pulse.

The controller behind the port takes a request on any cycle where `mem_req` is high. It returns read data on `mem_rdata` exactly `RD_LAT` cycles after the request cycle and needs no handshake. Frame positions below are for the default parameters: 100-cycle frame, 8-cycle CPU slots, 20-cycle video slots, `RD_LAT` = 5.

Top module: `mem_slot_sched`

## Requirements
- R1: A frame is 100 cycles long. `frm_sync` is high only in position 0 of each frame. The first cycle after reset is released is position 0.
- R2: `cpu_addr`, `cpu_we`, `cpu_wdata` and `vid_ofs` are sampled only at the clock edge that ends position 0. Changing them at any other time has no effect on that frame's commands or results.
- R3: In position 1 of every frame `mem_req` is high with a read command for word address `cpu_addr[15:1]`. This happens even when the request is a write. The command codes are: read = 0, write = 1, refresh = 2.
- R4: `cpu_rdata` is one byte of the word that comes back `RD_LAT` cycles after the position-1 read. When `cpu_addr[0]` = 0 it is bits 7:0; when `cpu_addr[0]` = 1 it is bits 15:8. The value is visible from position 7 and held until position 7 of the next frame.
- R5: For a write request, position 9 carries a write command to the same word. Its data is the word read in position 1 with the addressed byte replaced by `cpu_wdata`. For a read request, position 9 has no command.
- R6: Position 17 of every frame carries one refresh command.
- R7: Positions 37, 57 and 77 carry read commands for word addresses k*8192 + `vid_ofs`, for k = 0, 1, 2. A CPU write made earlier in the same frame is visible to these reads.
- R8: `vid_valid` is high only in position 83, for one cycle. In that same cycle all three words on `vid_words` change together: word k is at bits 16k+15:16k. The words hold their values at all other times.
- R9: `mem_req` is low in every position other than those named in R3, R5, R6 and R7.
- R10: A synchronous active-low reset clears `mem_req`, `cpu_rdata`, `vid_words` and `vid_valid`, and the frame restarts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory controller |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_we | input | 1 | CPU cycle is a write |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte read in this frame |
| frm_sync | output | 1 | High in frame position 0 |
| vid_ofs | input | 13 | Word offset used in all three video regions |
| vid_words | output | 48 | Three fetched video words |
| vid_valid | output | 1 | One-cycle pulse when new video words are presented |
| mem_req | output | 1 | Command valid this cycle |
| mem_cmd | output | 2 | 0 read, 1 write, 2 refresh |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, `RD_LAT` cycles after the read request |

## Verification
In the frame-start cycle, the CPU read command leaves using the live address while the same address, write flag and byte are latched for the write slot. The bench provokes this by replacing every CPU input with different values one cycle after the frame start. It judges the result by checking that the write slot still targets the latched word with the latched byte. A second overlap is a CPU write and a video fetch of the same word within one frame. This is driven in each of the three regions, including the last word of memory, and the video word must carry the freshly merged byte.

// File: rtl/sched_pkg.sv
// Package: shared command codes, slot indices and slot placement for the
// time-slotted memory scheduler. Assumes slot order CPU read, CPU write,
// refresh, then video fetches.
package sched_pkg;

    typedef enum logic [1:0] {
        MCMD_READ    = 2'd0,
        MCMD_WRITE   = 2'd1,
        MCMD_REFRESH = 2'd2
    } mem_cmd_e;

    localparam int SL_CPU_RD  = 0;
    localparam int SL_CPU_WR  = 1;
    localparam int SL_REFRESH = 2;
    localparam int SL_VID0    = 3;

    // Frame position at which slot s is decoded (command appears one cycle later).
    function automatic int slot_start(int s, int cpu_slot, int vid_slot);
        if (s <= SL_REFRESH)
            return s * cpu_slot;
        return 2 * cpu_slot + vid_slot * (s - SL_REFRESH);
    endfunction

endpackage

// File: rtl/sched_frame_timer.sv
// Frame timer: free-running counter over one frame, decoding the start of
// every slot and the cycle in which each read's data is on the return bus.
// Assumes the controller's read latency is fixed at RD_LAT cycles.
module sched_frame_timer
    import sched_pkg::*;
#(
    parameter int FRAME_CYC = 100,
    parameter int CPU_SLOT  = 8,
    parameter int VID_SLOT  = 20,
    parameter int RD_LAT    = 5,
    parameter int NUM_VID   = 3,
    localparam int NSLOT    = SL_VID0 + NUM_VID,
    localparam int CW       = $clog2(FRAME_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             frm_sync,
    output logic [NSLOT-1:0] slot_go,
    output logic [NUM_VID:0] cap_go
);

    logic [CW-1:0] cnt;

    // Frame position counter, wraps at FRAME_CYC-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(FRAME_CYC - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign frm_sync = (cnt == '0);

    // One decode per slot start.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_go[s] = (cnt == CW'(slot_start(s, CPU_SLOT, VID_SLOT)));
    end

    // Capture points: CPU read data, then each video word.
    assign cap_go[0] = (cnt == CW'(slot_start(SL_CPU_RD, CPU_SLOT, VID_SLOT) + 1 + RD_LAT));
    for (genvar k = 0; k < NUM_VID; k++) begin : g_cap
        assign cap_go[k+1] = (cnt == CW'(slot_start(SL_VID0 + k, CPU_SLOT, VID_SLOT) + 1 + RD_LAT));
    end

endmodule

// File: rtl/sched_cpu_port.sv
// CPU side: latches the byte request at frame start, captures the read word,
// presents the addressed byte and forms the merged word for the write slot.
// Assumes a 16-bit memory word holding two bytes, lane chosen by address bit 0.
module sched_cpu_port #(
    parameter int CPU_AW = 16,
    parameter int DW     = 16,
    localparam int BW    = DW / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              cap,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [BW-1:0]     cpu_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [CPU_AW-2:0] word_q,
    output logic              wr_pend,
    output logic [DW-1:0]     wr_word,
    output logic [BW-1:0]     cpu_rdata
);

    logic          hi_lane;
    logic [BW-1:0] wbyte_q;
    logic [DW-1:0] rd_word;

    // Request latch, sampled once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            hi_lane <= 1'b0;
            wr_pend <= 1'b0;
            wbyte_q <= '0;
        end else if (take) begin
            word_q  <= cpu_addr[CPU_AW-1:1];
            hi_lane <= cpu_addr[0];
            wr_pend <= cpu_we;
            wbyte_q <= cpu_wdata;
        end
    end

    // Read-data capture and byte selection for the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word   <= '0;
            cpu_rdata <= '0;
        end else if (cap) begin
            rd_word   <= mem_rdata;
            cpu_rdata <= hi_lane ? mem_rdata[DW-1:BW] : mem_rdata[BW-1:0];
        end
    end

    // Merge the CPU byte into the word read earlier in the frame.
    always_comb begin
        wr_word = hi_lane ? {wbyte_q, rd_word[BW-1:0]} : {rd_word[DW-1:BW], wbyte_q};
    end

endmodule

// File: rtl/sched_vid_port.sv
// Video side: latches the word offset at frame start, stages each fetched
// word and presents all of them at once with a one-cycle valid pulse.
// Assumes captures arrive in region order, the last one ending the frame's fetch.
module sched_vid_port #(
    parameter int NUM_VID = 3,
    parameter int DW      = 16,
    parameter int REG_AW  = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [NUM_VID-1:0]    cap_go,
    input  logic [REG_AW-1:0]     vid_ofs,
    input  logic [DW-1:0]         mem_rdata,
    output logic [REG_AW-1:0]     ofs_q,
    output logic [NUM_VID*DW-1:0] vid_words,
    output logic                  vid_valid
);

    logic [DW-1:0] stage [NUM_VID-1];

    // Offset latch, sampled once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs_q <= '0;
        else if (take)
            ofs_q <= vid_ofs;
    end

    // Hold early words until the last region's word returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_VID - 1; k++) stage[k] <= '0;
        end else begin
            for (int k = 0; k < NUM_VID - 1; k++)
                if (cap_go[k]) stage[k] <= mem_rdata;
        end
    end

    // Present all words together and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_words <= '0;
            vid_valid <= 1'b0;
        end else if (cap_go[NUM_VID-1]) begin
            for (int k = 0; k < NUM_VID - 1; k++)
                vid_words[k*DW +: DW] <= stage[k];
            vid_words[(NUM_VID-1)*DW +: DW] <= mem_rdata;
            vid_valid <= 1'b1;
        end else begin
            vid_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/mem_slot_sched.sv
// Top: time-slotted scheduler sharing one fixed-latency memory port between
// a byte-wide CPU (read-merge-write) and a three-region video fetch.
// Assumes the controller accepts one command per cycle with no back-pressure.
module mem_slot_sched
    import sched_pkg::*;
#(
    parameter int FRAME_CYC = 100,
    parameter int CPU_SLOT  = 8,
    parameter int VID_SLOT  = 20,
    parameter int RD_LAT    = 5,
    parameter int NUM_VID   = 3,
    parameter int REG_AW    = 13,
    parameter int DW        = 16,
    localparam int MEM_AW   = REG_AW + $clog2(NUM_VID),
    localparam int CPU_AW   = MEM_AW + 1,
    localparam int BW       = DW / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic                  cpu_we,
    input  logic [BW-1:0]         cpu_wdata,
    output logic [BW-1:0]         cpu_rdata,
    output logic                  frm_sync,
    input  logic [REG_AW-1:0]     vid_ofs,
    output logic [NUM_VID*DW-1:0] vid_words,
    output logic                  vid_valid,
    output logic                  mem_req,
    output logic [1:0]            mem_cmd,
    output logic [MEM_AW-1:0]     mem_addr,
    output logic [DW-1:0]         mem_wdata,
    input  logic [DW-1:0]         mem_rdata
);

    localparam int NSLOT = SL_VID0 + NUM_VID;

    logic [NSLOT-1:0]   slot_go;
    logic [NUM_VID:0]   cap_go;
    logic [CPU_AW-2:0]  word_q;
    logic               wr_pend;
    logic [DW-1:0]      wr_word;
    logic [REG_AW-1:0]  ofs_q;

    sched_frame_timer #(
        .FRAME_CYC(FRAME_CYC), .CPU_SLOT(CPU_SLOT), .VID_SLOT(VID_SLOT),
        .RD_LAT(RD_LAT), .NUM_VID(NUM_VID)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync),
        .slot_go(slot_go), .cap_go(cap_go)
    );

    sched_cpu_port #(.CPU_AW(CPU_AW), .DW(DW)) u_cpu (
        .clk(clk), .rst_n(rst_n), .take(slot_go[SL_CPU_RD]), .cap(cap_go[0]),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .mem_rdata(mem_rdata), .word_q(word_q), .wr_pend(wr_pend),
        .wr_word(wr_word), .cpu_rdata(cpu_rdata)
    );

    sched_vid_port #(.NUM_VID(NUM_VID), .DW(DW), .REG_AW(REG_AW)) u_vid (
        .clk(clk), .rst_n(rst_n), .take(slot_go[SL_CPU_RD]),
        .cap_go(cap_go[NUM_VID:1]), .vid_ofs(vid_ofs), .mem_rdata(mem_rdata),
        .ofs_q(ofs_q), .vid_words(vid_words), .vid_valid(vid_valid)
    );

    // Command issue: one registered command per slot start; idle write slot sends nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_cmd   <= MCMD_READ;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_req <= 1'b0;
            if (slot_go[SL_CPU_RD]) begin
                mem_req  <= 1'b1;
                mem_cmd  <= MCMD_READ;
                mem_addr <= cpu_addr[CPU_AW-1:1];
            end
            if (slot_go[SL_CPU_WR] && wr_pend) begin
                mem_req   <= 1'b1;
                mem_cmd   <= MCMD_WRITE;
                mem_addr  <= word_q;
                mem_wdata <= wr_word;
            end
            if (slot_go[SL_REFRESH]) begin
                mem_req  <= 1'b1;
                mem_cmd  <= MCMD_REFRESH;
                mem_addr <= '0;
            end
            for (int k = 0; k < NUM_VID; k++) begin
                if (slot_go[SL_VID0 + k]) begin
                    mem_req  <= 1'b1;
                    mem_cmd  <= MCMD_READ;
                    mem_addr <= (MEM_AW'(k) << REG_AW) | MEM_AW'(ofs_q);
                end
            end
        end
    end

endmodule

// File: rtl/sched_checker.sv
// Checker: timing properties of the slot schedule, bound to mem_slot_sched.
// Keeps its own frame position counter, independent of the design's timer.
module sched_checker
    import sched_pkg::*;
#(
    parameter int FRAME_CYC = 100,
    parameter int CPU_SLOT  = 8,
    parameter int VID_SLOT  = 20,
    parameter int RD_LAT    = 5,
    parameter int NUM_VID   = 3,
    parameter int MEM_AW    = 15,
    parameter int BW        = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_sync,
    input logic              mem_req,
    input logic [1:0]        mem_cmd,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [BW-1:0]     cpu_rdata,
    input logic              vid_valid
);

    localparam int RD_POS  = slot_start(SL_CPU_RD, CPU_SLOT, VID_SLOT) + 1;
    localparam int WR_POS  = slot_start(SL_CPU_WR, CPU_SLOT, VID_SLOT) + 1;
    localparam int REF_POS = slot_start(SL_REFRESH, CPU_SLOT, VID_SLOT) + 1;
    localparam int CPU_VIS = RD_POS + RD_LAT + 1;
    localparam int VV_POS  = slot_start(SL_VID0 + NUM_VID - 1, CPU_SLOT, VID_SLOT) + 2 + RD_LAT;

    int unsigned       pos;
    logic [MEM_AW-1:0] rd_seen;

    // Reference frame position.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pos <= 0;
        else if (pos == FRAME_CYC - 1) pos <= 0;
        else                          pos <= pos + 1;
    end

    // Word address of this frame's CPU read.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rd_seen <= '0;
        else if (mem_req && pos == RD_POS) rd_seen <= mem_addr;
    end

    assert_frame_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_sync == (pos == 0));

    assert_cpu_read_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == RD_POS) |-> (mem_req && mem_cmd == MCMD_READ));

    assert_cpu_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != CPU_VIS) |-> $stable(cpu_rdata));

    assert_write_same_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_cmd == MCMD_WRITE) |-> (pos == WR_POS && mem_addr == rd_seen));

    assert_refresh_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == REF_POS) |-> (mem_req && mem_cmd == MCMD_REFRESH));

    for (genvar k = 0; k < NUM_VID; k++) begin : g_vchk
        assert_video_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pos == slot_start(SL_VID0 + k, CPU_SLOT, VID_SLOT) + 1) |->
            (mem_req && mem_cmd == MCMD_READ));
    end

    assert_vid_valid_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> (pos == VV_POS));

    assert_vid_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |=> !vid_valid);

    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

endmodule

bind mem_slot_sched sched_checker #(
    .FRAME_CYC(FRAME_CYC), .CPU_SLOT(CPU_SLOT), .VID_SLOT(VID_SLOT),
    .RD_LAT(RD_LAT), .NUM_VID(NUM_VID), .MEM_AW(MEM_AW), .BW(BW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .mem_req(mem_req),
    .mem_cmd(mem_cmd), .mem_addr(mem_addr), .cpu_rdata(cpu_rdata),
    .vid_valid(vid_valid)
);

// File: tb/mem_slot_sched_tb.sv
module mem_slot_sched_tb;

    localparam int FRAME = 100;
    localparam int LAT   = 5;

    typedef struct packed {
        logic [15:0] a;
        logic        we;
        logic [7:0]  d;
        logic [12:0] o;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{16'h0000, 1'b0, 8'h00, 13'h0000},
        '{16'h0001, 1'b1, 8'hA5, 13'h0000},
        '{16'h0001, 1'b0, 8'h00, 13'h1FFF},
        '{16'h4000, 1'b1, 8'h3C, 13'h0000},
        '{16'hBFFF, 1'b1, 8'h81, 13'h1FFF},
        '{16'hBFFF, 1'b0, 8'h00, 13'h0ABC},
        '{16'h2468, 1'b1, 8'h7E, 13'h1234},
        '{16'h2468, 1'b0, 8'h00, 13'h0555}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        frm_sync;
    logic [12:0] vid_ofs = '0;
    logic [47:0] vid_words;
    logic        vid_valid;
    logic        mem_req;
    logic [1:0]  mem_cmd;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mem_slot_sched u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .frm_sync(frm_sync),
        .vid_ofs(vid_ofs), .vid_words(vid_words), .vid_valid(vid_valid),
        .mem_req(mem_req), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: sparse storage over a computed background pattern.
    logic [15:0] mem_m [int unsigned];
    logic [15:0] pipe [LAT];

    function automatic logic [15:0] rd_word(int unsigned a);
        if (mem_m.exists(a)) return mem_m[a];
        return 16'((a * 40503) ^ 23130);
    endfunction

    assign mem_rdata = pipe[LAT-1];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected frame state, derived from the requirements at the frame-start edge.
    int          pos;
    logic [14:0] e_word;
    logic        e_we;
    logic [7:0]  e_byte;
    logic [15:0] e_wr;
    logic [14:0] e_vaddr [3];
    logic [15:0] e_vid [3];

    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else pos <= (pos == FRAME - 1) ? 0 : pos + 1;
        for (int i = LAT - 1; i > 0; i--) pipe[i] <= pipe[i-1];
        pipe[0] <= (mem_req && mem_cmd == 2'd0) ? rd_word(32'(mem_addr)) : 16'hDEAD;
        if (mem_req && mem_cmd == 2'd1) mem_m[32'(mem_addr)] = mem_wdata;
        if (rst_n && pos == 0) begin
            logic [15:0] pre;
            e_word = cpu_addr[15:1];
            e_we   = cpu_we;
            pre    = rd_word(32'(e_word));
            e_byte = cpu_addr[0] ? pre[15:8] : pre[7:0];
            e_wr   = cpu_addr[0] ? {cpu_wdata, pre[7:0]} : {pre[15:8], cpu_wdata};
            for (int k = 0; k < 3; k++) begin
                e_vaddr[k] = 15'(k * 8192) | 15'(vid_ofs);
                e_vid[k]   = (cpu_we && e_vaddr[k] == e_word) ? e_wr : rd_word(32'(e_vaddr[k]));
            end
        end
    end

    // Monitor: every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_req;
            string tag;
            exp_req = (pos == 1) || (pos == 9 && e_we) || (pos == 17) ||
                      (pos == 37) || (pos == 57) || (pos == 77);
            tag = (pos == 1) ? "R3" : (pos == 9) ? "R5" : (pos == 17) ? "R6" :
                  (pos == 37 || pos == 57 || pos == 77) ? "R7" : "R9";
            if (frm_sync || pos == 0)
                chk(frm_sync == (pos == 0), "R1 frame sync", 64'(frm_sync), 64'(pos == 0));
            if (exp_req || mem_req)
                chk(mem_req == exp_req, {tag, " request"}, 64'(mem_req), 64'(exp_req));
            if (exp_req && mem_req) begin
                if (pos == 1) begin
                    chk(mem_cmd == 2'd0, "R3 read cmd", 64'(mem_cmd), 64'd0);
                    chk(mem_addr == e_word, "R3 read addr", 64'(mem_addr), 64'(e_word));
                end else if (pos == 9) begin
                    chk(mem_cmd == 2'd1, "R5 write cmd", 64'(mem_cmd), 64'd1);
                    chk(mem_addr == e_word, "R5 write addr", 64'(mem_addr), 64'(e_word));
                    chk(mem_wdata == e_wr, "R5 merged data", 64'(mem_wdata), 64'(e_wr));
                end else if (pos == 17) begin
                    chk(mem_cmd == 2'd2, "R6 refresh cmd", 64'(mem_cmd), 64'd2);
                end else begin
                    int k;
                    k = (pos - 37) / 20;
                    chk(mem_cmd == 2'd0, "R7 video cmd", 64'(mem_cmd), 64'd0);
                    chk(mem_addr == e_vaddr[k], "R7 video addr", 64'(mem_addr), 64'(e_vaddr[k]));
                end
            end
            if (pos == 7 || pos == 99)
                chk(cpu_rdata == e_byte, "R4 cpu byte", 64'(cpu_rdata), 64'(e_byte));
            if (vid_valid || pos == 83)
                chk(vid_valid == (pos == 83), "R8 valid pulse", 64'(vid_valid), 64'(pos == 83));
            if (pos == 83)
                for (int k = 0; k < 3; k++)
                    chk(vid_words[k*16 +: 16] == e_vid[k], "R8 video word",
                        64'(vid_words[k*16 +: 16]), 64'(e_vid[k]));
        end
    end

    task automatic next_frame();
        do @(negedge clk); while (!frm_sync);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(mem_req == 1'b0 && vid_valid == 1'b0, "R10 reset req/valid", 64'({mem_req, vid_valid}), 64'd0);
        chk(cpu_rdata == 8'h00 && vid_words == 48'h0, "R10 reset data", 64'(cpu_rdata), 64'd0);
        rst_n = 1'b1;
        chk(frm_sync == 1'b1, "R1 first cycle is frame start", 64'(frm_sync), 64'd1);

        // Vector table walk
        for (int i = 0; i < 8; i++) begin
            next_frame();
            cpu_addr  = VEC[i].a;
            cpu_we    = VEC[i].we;
            cpu_wdata = VEC[i].d;
            vid_ofs   = VEC[i].o;
        end
        next_frame();
        cpu_we = 1'b0;

        // R2: inputs changed right after the sampling edge must be ignored
        next_frame();
        cpu_addr = 16'h0102; cpu_we = 1'b1; cpu_wdata = 8'h11; vid_ofs = 13'h0100;
        @(negedge clk);
        cpu_addr = 16'h3333; cpu_we = 1'b0; cpu_wdata = 8'hFF; vid_ofs = 13'h0777;
        @(negedge clk);
        cpu_addr = 16'h0103; cpu_we = 1'b1; cpu_wdata = 8'h22;
        next_frame();
        cpu_we = 1'b0;

        // R10: reset in mid-frame
        next_frame();
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0 && vid_valid == 1'b0, "R10 mid reset req/valid", 64'({mem_req, vid_valid}), 64'd0);
        chk(cpu_rdata == 8'h00 && vid_words == 48'h0, "R10 mid reset data", 64'(cpu_rdata), 64'd0);
        cpu_addr = 16'h0001; cpu_we = 1'b1; cpu_wdata = 8'h5A; vid_ofs = 13'h0000;
        rst_n = 1'b1;
        chk(frm_sync == 1'b1, "R10 frame restarts", 64'(frm_sync), 64'd1);
        @(negedge clk);
        cpu_we = 1'b0;
        next_frame();
        next_frame();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

endmodule